// File: doc/BRIEF.md
# QPSK Symbol Modulator

The block turns a 32-bit parallel data word into a quadrature phase-keyed carrier sample stream. A load strobe, accepted only while the block is idle, captures the word. The word is then sent most significant pair first as 16 two-bit symbols. Symbol timing comes from a divide-by-32 counter on the system clock, and each symbol lasts two divided bit periods (64 clocks).

Each symbol sets the signs of two orthogonal carriers of the same frequency. These are a cosine and a sine, each quantized to 16 samples per period with a peak of 127. One sample is produced per clock, and the two carrier terms are added into a single signed 9-bit passband sample. The two carrier signs are also driven out so the constellation point can be observed. The carrier phase index restarts at zero at every symbol boundary. When the last symbol ends, a one-cycle done flag is raised and the block returns to idle.

Top module: `qpsk_mod`

## Requirements
- R1: While reset is asserted, and after it is released, `busy_o`, `done_o`, `i_neg_o`, `q_neg_o` are 0 and `sample_o` is 0. An asynchronous reset asserted mid-word abandons the word.
- R2: A `load_i` high at a clock edge while `busy_o` is 0 captures `word_i`. `busy_o` is 1 from that edge on, and symbol 0 with phase index 0 is presented in the following cycle.
- R3: A `load_i` at an edge while `busy_o` is 1 is ignored. The ongoing word continues unchanged.
- R4: Symbol n (n = 0..15) is formed from bits [31-2n] (first bit) and [30-2n] (second bit) of the captured word.
- R5: `i_neg_o` equals the first bit of the current symbol and `q_neg_o` equals the second bit. 0 means a positive carrier and 1 means a negative carrier. The constellation point (I,Q) is therefore 00 to (+,+), 10 to (-,+), 11 to (-,-) and 01 to (+,-). These are the odd multiples of 45 degrees in Gray order.
- R6: Each symbol lasts exactly 64 clocks, which is two periods of the divide-by-32 counter. The signs change only at those boundaries.
- R7: The phase index k is the number of clocks since the start of the current symbol, modulo 16. The cosine value is round(127·cos(2πk/16)) and the sine value is round(127·sin(2πk/16)). The quarter values are 127, 117, 90, 49 and 0.
- R8: While busy, `sample_o` = (1−2·i_neg)·cos(k) + (1−2·q_neg)·sin(k) as a 9-bit two's complement value. Its magnitude never exceeds 180.
- R9: `done_o` is a one-cycle pulse in the cycle right after the 16th symbol ends, which is 1024 cycles after the load edge. `busy_o` falls in that same cycle. A new load is accepted at the done cycle.
- R10: While idle, `sample_o`, `i_neg_o` and `q_neg_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture strobe for the data word |
| word_i | input | 32 | Parallel data word |
| busy_o | output | 1 | A word is being transmitted |
| done_o | output | 1 | One-cycle pulse after the last symbol |
| i_neg_o | output | 1 | In-phase carrier sign, 1 = negative |
| q_neg_o | output | 1 | Quadrature carrier sign, 1 = negative |
| sample_o | output | 9 | Signed passband sample |

## Verification
A wrong symbol counter or shift position shows at the sign outputs and in the sample, either one symbol boundary late or for the whole word. A wrong divider or phase counter changes the sample within a few clocks of the first symbol, because the bench compares every clock. A wrong end count moves the done pulse away from cycle 1024, so it is detected at the end of the first word. Loads during transmission are injected mid-word, so a restarted word would corrupt the very next samples.

// File: rtl/qpsk_pkg.sv
package qpsk_pkg;
  localparam int SYM_BITS = 2;
  localparam int PH_W     = 4;
  localparam int CAR_W    = 8;
  localparam int SAMP_W   = CAR_W + 1;

  typedef logic signed [CAR_W-1:0]  car_t;
  typedef logic signed [SAMP_W-1:0] samp_t;
  typedef logic [PH_W-1:0]          phase_t;

  // quarter-wave magnitudes for steps 0..4 of a 16-step period
  function automatic car_t quarter_mag(input logic [2:0] idx);
    case (idx)
      3'd0:    return car_t'(127);
      3'd1:    return car_t'(117);
      3'd2:    return car_t'(90);
      3'd3:    return car_t'(49);
      default: return car_t'(0);
    endcase
  endfunction

  function automatic car_t cos_lookup(input phase_t k);
    logic [2:0] fwd;
    logic [2:0] rev;
    fwd = {1'b0, k[1:0]};
    rev = 3'd4 - {1'b0, k[1:0]};
    case (k[3:2])
      2'd0:    return quarter_mag(fwd);
      2'd1:    return -quarter_mag(rev);
      2'd2:    return -quarter_mag(fwd);
      default: return quarter_mag(rev);
    endcase
  endfunction

  // sin(k) = cos(k - 4) on a 16-step circle
  function automatic car_t sin_lookup(input phase_t k);
    return cos_lookup(k + phase_t'(12));
  endfunction
endpackage

// File: rtl/qpsk_symtimer.sv
module qpsk_symtimer #(
  parameter int DIV_N    = 32,
  parameter int SYM_BITS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic sym_end
);
  localparam int DIV_W = (DIV_N > 1) ? $clog2(DIV_N) : 1;
  localparam int BIT_W = (SYM_BITS > 1) ? $clog2(SYM_BITS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_N - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SYM_BITS - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             div_wrap;

  assign div_wrap = run && (div_q == DIV_LAST);
  assign sym_end  = div_wrap && (bit_q == BIT_LAST);

  always_comb begin
    div_d = div_q;
    bit_d = bit_q;
    if (start) begin
      div_d = '0;
      bit_d = '0;
    end else if (run) begin
      div_d = div_wrap ? '0 : div_q + 1'b1;
      if (div_wrap) begin
        bit_d = (bit_q == BIT_LAST) ? '0 : bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      bit_q <= '0;
    end else begin
      div_q <= div_d;
      bit_q <= bit_d;
    end
  end
endmodule

// File: rtl/qpsk_piso.sv
module qpsk_piso #(
  parameter int WORD_W   = 32,
  parameter int SYM_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [WORD_W-1:0]   word,
  input  logic                sym_end,
  output logic                busy,
  output logic                done,
  output logic [SYM_BITS-1:0] symbol
);
  localparam int NSYM  = WORD_W / SYM_BITS;
  localparam int CNT_W = (NSYM > 1) ? $clog2(NSYM) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NSYM - 1);

  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    if (start) begin
      shreg_d = word;
      cnt_d   = '0;
      busy_d  = 1'b1;
    end else if (busy_q && sym_end) begin
      shreg_d = shreg_q << SYM_BITS;
      if (cnt_q == CNT_LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign symbol = shreg_q[WORD_W-1 -: SYM_BITS];
endmodule

// File: rtl/qpsk_carrier.sv
module qpsk_carrier
  import qpsk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   run,
  input  logic   sym_end,
  output car_t   cos_v,
  output car_t   sin_v
);
  phase_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (start || (run && sym_end)) begin
      ph_d = '0;
    end else if (run) begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign cos_v = cos_lookup(ph_q);
  assign sin_v = sin_lookup(ph_q);
endmodule

// File: rtl/qpsk_mapper.sv
module qpsk_mapper
  import qpsk_pkg::*;
(
  input  logic                active,
  input  logic [SYM_BITS-1:0] symbol,
  input  car_t                cos_v,
  input  car_t                sin_v,
  output logic                i_neg,
  output logic                q_neg,
  output samp_t               sample
);
  samp_t i_term, q_term;

  assign i_neg = active & symbol[SYM_BITS-1];
  assign q_neg = active & symbol[SYM_BITS-2];

  always_comb begin
    i_term = i_neg ? -samp_t'(cos_v) : samp_t'(cos_v);
    q_term = q_neg ? -samp_t'(sin_v) : samp_t'(sin_v);
    sample = active ? (i_term + q_term) : '0;
  end
endmodule

// File: rtl/qpsk_mod.sv
module qpsk_mod
  import qpsk_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_N  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              i_neg_o,
  output logic              q_neg_o,
  output logic [SAMP_W-1:0] sample_o
);
  logic [1:0]          rst_pipe;
  logic                rst_sync_n;
  logic                busy, done, start, sym_end;
  logic [SYM_BITS-1:0] symbol;
  car_t                cos_v, sin_v;
  samp_t               sample;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  assign start = load_i && !busy;

  qpsk_symtimer #(.DIV_N(DIV_N), .SYM_BITS(SYM_BITS)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .run(busy), .sym_end(sym_end)
  );

  qpsk_piso #(.WORD_W(WORD_W), .SYM_BITS(SYM_BITS)) u_piso (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .word(word_i),
    .sym_end(sym_end), .busy(busy), .done(done), .symbol(symbol)
  );

  qpsk_carrier u_carrier (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .run(busy),
    .sym_end(sym_end), .cos_v(cos_v), .sin_v(sin_v)
  );

  qpsk_mapper u_mapper (
    .active(busy), .symbol(symbol), .cos_v(cos_v), .sin_v(sin_v),
    .i_neg(i_neg_o), .q_neg(q_neg_o), .sample(sample)
  );

  assign busy_o   = busy;
  assign done_o   = done;
  assign sample_o = sample;
endmodule

// File: rtl/qpsk_mod_chk.sv
module qpsk_mod_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       i_neg_o,
  input logic       q_neg_o,
  input logic [8:0] sample_o
);
  logic [9:0] t_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '0;
    end else if (load_i && !busy_o) begin
      t_q <= '0;
    end else if (busy_o) begin
      t_q <= t_q + 1'b1;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R2
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !busy_o) |=> busy_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (sample_o == 9'd0 && !i_neg_o && !q_neg_o));

  // R8
  sample_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(sample_o) <= 180 && $signed(sample_o) >= -180));

  // R6
  sign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && t_q[5:0] != 6'd0) |-> ($stable(i_neg_o) && $stable(q_neg_o)));
endmodule

bind qpsk_mod qpsk_mod_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .load_i(load_i), .busy_o(busy_o),
  .done_o(done_o), .i_neg_o(i_neg_o), .q_neg_o(q_neg_o), .sample_o(sample_o)
);

// File: tb/tb_qpsk_mod.sv
module tb_qpsk_mod;
  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic [31:0] word_i;
  logic        busy_o, done_o, i_neg_o, q_neg_o;
  logic [8:0]  sample_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 0;

  qpsk_mod dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .word_i(word_i),
    .busy_o(busy_o), .done_o(done_o), .i_neg_o(i_neg_o),
    .q_neg_o(q_neg_o), .sample_o(sample_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      finish_run();
    end
  end

  task automatic expect_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic int rnd127(real x);
    real v;
    v = 127.0 * x;
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int exp_sample(logic [31:0] w, int t);
    int sym, k, c, s;
    real ang;
    sym = t / 64;
    k   = t % 16;
    ang = 6.283185307179586 * k / 16.0;
    c = rnd127($cos(ang));
    s = rnd127($sin(ang));
    return (w[31-2*sym] ? -c : c) + (w[30-2*sym] ? -s : s);
  endfunction

  task automatic check_idle(string req);
    expect_eq({req, " busy"}, int'(busy_o), 0);
    expect_eq({req, " done"}, int'(done_o), 0);
    expect_eq({req, " ineg"}, int'(i_neg_o), 0);
    expect_eq({req, " qneg"}, int'(q_neg_o), 0);
    expect_eq({req, " sample"}, int'($signed(sample_o)), 0);
  endtask

  // entered and left at a falling edge; inject_t >= 0 drives a load mid-word
  task automatic run_word(logic [31:0] w, int inject_t);
    load_i = 1'b1;
    word_i = w;
    @(negedge clk);
    load_i = 1'b0;
    word_i = ~w;
    for (int t = 0; t < 1024; t++) begin
      int sym;
      sym = t / 64;
      expect_eq("R2 busy", int'(busy_o), 1);
      expect_eq("R9 done low", int'(done_o), 0);
      expect_eq("R4/R5 i sign", int'(i_neg_o), int'(w[31-2*sym]));
      expect_eq("R5/R6 q sign", int'(q_neg_o), int'(w[30-2*sym]));
      expect_eq("R7/R8 sample", int'($signed(sample_o)), exp_sample(w, t));
      if (t == inject_t) load_i = 1'b1;  // R3 ignored load
      @(negedge clk);
      load_i = 1'b0;
    end
    expect_eq("R9 done pulse", int'(done_o), 1);
    expect_eq("R9 busy fall", int'(busy_o), 0);
    expect_eq("R10 idle sample", int'($signed(sample_o)), 0);
  endtask

  initial begin
    logic [31:0] w;
    void'($urandom(32'h5EED_0042));
    rst_n  = 1'b0;
    load_i = 1'b0;
    word_i = '0;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 after reset");

    run_word(32'h0000_0000, -1);
    run_word(32'hFFFF_FFFF, 200);
    run_word(32'h1B1B_1B1B, 64);
    run_word(32'hE4E4_E4E4, 1023);
    for (int i = 0; i < 4; i++) begin
      w = $urandom;
      run_word(w, int'($urandom % 1024));
    end
    @(negedge clk);
    check_idle("R9/R10 after done");
    repeat (5) @(negedge clk);
    check_idle("R10 idle");

    // R1 reset mid-word
    load_i = 1'b1;
    word_i = 32'hA5A5_5A5A;
    @(negedge clk);
    load_i = 1'b0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle("R1 mid-word reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 released");

    run_word(32'h9C3F_0E71, -1);
    @(negedge clk);
    check_idle("R10 final idle");
    finish_run();
  end
endmodule